// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reset request of a small microcontroller into one chip-wide reset line. The request sources are a filtered active-low reset pin, a power-on pulse, a brown-out detector that is honoured only when enabled, and a watchdog time-out. Once a request is seen, the block holds the chip in reset through two start-up delays that run one after the other. The first is a power-up delay that counts cycles of a free-running internal RC clock. The second is an oscillator start-up delay that counts cycles of the main oscillator clock. Each delay can be bypassed on its own.

For every event the block also records a 3-bit cause code and two status flags, a time-out flag and a power-down flag, so that firmware can tell which kind of reset happened. When a watchdog time-out arrives while the core is asleep, the block treats it as a wake-up and not as a reset. It reports the wake-up with a one-cycle strobe and a cause code, and it leaves the chip reset line alone.

The block never drives the reset pin. The pin is an input only. The power-on, brown-out, watchdog and sleep inputs are synchronous to the oscillator clock. The reset pin and the RC-domain handshake are resynchronised inside the block.

Top module: `rst_seq_top`

## Requirements
- R1: While rst_ni is low: chip_rst_o=1, cause_o=0, to_o=1, pd_o=1 and wake_o=0. After rst_ni is released, the block runs a full release sequence and logs it as power-on.
- R2: A low level on ext_rst_ni shorter than FILT_LEN consecutive oscillator samples has no effect. A longer low level raises chip_rst_o and keeps it high for as long as the pin stays low.
- R3: A pin reset while sleep_i=0 sets cause_o=1 and leaves to_o and pd_o unchanged.
- R4: A pin reset while sleep_i=1 sets cause_o=2, to_o=1, pd_o=0.
- R5: A watchdog time-out (rising edge of wdt_to_i) while sleep_i=0 and chip_rst_o=0 starts a reset with cause_o=3, to_o=0, pd_o=1.
- R6: bod_i causes a reset with cause_o=4, to_o=1, pd_o=1 only when bod_en_i=1. With bod_en_i=0 it has no effect.
- R7: A watchdog time-out while sleep_i=1 and chip_rst_o=0 does not reset the chip. It gives a one-cycle wake_o pulse with cause_o=5, to_o=0, pd_o=0.
- R8: A power-on pulse sets cause_o=0, to_o=1, pd_o=1. It wins over any other source that arrives in the same cycle.
- R9: With both delays enabled, chip_rst_o falls no earlier than PWRT_LEN RC cycles plus OST_LEN oscillator cycles after the last source goes inactive. The power-up delay completes before the start-up delay begins.
- R10: pwrt_en_i=0 skips the power-up delay and ost_en_i=0 skips the start-up delay. With both low, release follows within a few oscillator cycles.
- R11: A new reset event while the delays are running restarts the whole sequence from that event.
- R12: Watchdog time-outs that arrive while chip_rst_o=1 are ignored. They change neither the cause nor the status flags, and they give no wake pulse.
- R13: chip_rst_o is set by any reset event and cleared only when the delay chain finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Main oscillator clock |
| rc_clk_i | input | 1 | Free-running internal RC clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| por_i | input | 1 | Power-on pulse |
| bod_i | input | 1 | Brown-out detected |
| bod_en_i | input | 1 | Brown-out reset enable |
| wdt_to_i | input | 1 | Watchdog time-out |
| sleep_i | input | 1 | Core is asleep |
| pwrt_en_i | input | 1 | Enable power-up delay |
| ost_en_i | input | 1 | Enable oscillator start-up delay |
| chip_rst_o | output | 1 | Chip-wide reset, active high |
| cause_o | output | 3 | Last reset or wake cause code |
| to_o | output | 1 | Time-out status flag |
| pd_o | output | 1 | Power-down status flag |
| wake_o | output | 1 | One-cycle watchdog wake-up strobe |

## Verification
The bench builds the block with FILT_LEN=4, PWRT_LEN=16 and OST_LEN=16. With these values every full release sequence finishes in well under a microsecond, so a single run can cover all five reset kinds, the wake-up, both bypasses and a restart in the middle of a delay. The RC clock runs at a period that is not related to the oscillator period, so the request/acknowledge handshake between the two clock domains is exercised on every sequence. Release times are checked against windows derived from the two delay lengths.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    CAUSE_POR     = 3'd0,
    CAUSE_PIN_RUN = 3'd1,
    CAUSE_PIN_SLP = 3'd2,
    CAUSE_WDT     = 3'd3,
    CAUSE_BOR     = 3'd4,
    CAUSE_WAKE    = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_PWRUP = 2'd1,
    ST_OSCUP = 2'd2,
    ST_RUN   = 2'd3
  } seq_e;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic active_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_ni};
      if (sync_q[1])         cnt_q <= '0;
      else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o = (cnt_q == FULL);

  // R2
  filt_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(!sync_q[1]));
endmodule

// File: rtl/rst_rc_timer.sv
module rst_rc_timer #(
  parameter int unsigned LEN = 1024
) (
  input  logic rc_clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o,
  output logic echo_o
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [1:0]    run_sync;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge rc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_sync <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      run_sync <= {run_sync[0], run_i};
      if (!run_sync[1]) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (!done_q) begin
        if (cnt_q == LAST) done_q <= 1'b1;
        else               cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign echo_o = run_sync[1];

  // R9
  pwrt_req_chk: assert property (@(posedge rc_clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(run_sync[1]));
endmodule

// File: rtl/rst_cause_track.sv
module rst_cause_track
  import rst_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   por_ev_i,
  input  logic   bor_ev_i,
  input  logic   pin_ev_i,
  input  logic   wdt_ev_i,
  input  logic   wake_ev_i,
  input  logic   sleep_i,
  output cause_e cause_o,
  output logic   to_o,
  output logic   pd_o,
  output logic   wake_o
);
  cause_e cause_q;
  logic   to_q, pd_q, wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_POR;
      to_q    <= 1'b1;
      pd_q    <= 1'b1;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= wake_ev_i;
      // fixed priority: power-on, brown-out, pin, watchdog, wake
      if (por_ev_i) begin
        cause_q <= CAUSE_POR; to_q <= 1'b1; pd_q <= 1'b1;
      end else if (bor_ev_i) begin
        cause_q <= CAUSE_BOR; to_q <= 1'b1; pd_q <= 1'b1;
      end else if (pin_ev_i) begin
        if (sleep_i) begin
          cause_q <= CAUSE_PIN_SLP; to_q <= 1'b1; pd_q <= 1'b0;
        end else begin
          cause_q <= CAUSE_PIN_RUN;
        end
      end else if (wdt_ev_i) begin
        cause_q <= CAUSE_WDT; to_q <= 1'b0; pd_q <= 1'b1;
      end else if (wake_ev_i) begin
        cause_q <= CAUSE_WAKE; to_q <= 1'b0; pd_q <= 1'b0;
      end
    end
  end

  assign cause_o = cause_q;
  assign to_o    = to_q;
  assign pd_o    = pd_q;
  assign wake_o  = wake_q;

  // R3
  pin_run_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_q == CAUSE_PIN_RUN && $past(cause_q) == CAUSE_WDT) |-> (to_q == 1'b0));
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned FILT_LEN = 4,
  parameter int unsigned PWRT_LEN = 1024,
  parameter int unsigned OST_LEN  = 1024
) (
  input  logic       osc_clk_i,
  input  logic       rc_clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       por_i,
  input  logic       bod_i,
  input  logic       bod_en_i,
  input  logic       wdt_to_i,
  input  logic       sleep_i,
  input  logic       pwrt_en_i,
  input  logic       ost_en_i,
  output logic       chip_rst_o,
  output logic [2:0] cause_o,
  output logic       to_o,
  output logic       pd_o,
  output logic       wake_o
);
  localparam int unsigned OCW = (OST_LEN > 1) ? $clog2(OST_LEN) : 1;
  localparam logic [OCW-1:0] OST_LAST = OCW'(OST_LEN - 1);

  logic pin_act, pin_act_q, por_q, bor_q, wdt_q;
  logic bor_lvl, por_ev, bor_ev, pin_ev, wdt_edge, wdt_rst_ev, wake_ev;
  logic rst_ev, restart;
  logic run_q, rc_done, rc_echo;
  logic [1:0] done_sync, echo_sync;
  logic done_s, echo_s;
  seq_e state_q, state_d;
  logic [OCW-1:0] ost_cnt_q;
  logic chip_rst_q, seq_done;
  cause_e cause_w;

  rst_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i(osc_clk_i), .rst_ni(rst_ni), .pin_ni(ext_rst_ni), .active_o(pin_act)
  );

  rst_rc_timer #(.LEN(PWRT_LEN)) u_pwrt (
    .rc_clk_i(rc_clk_i), .rst_ni(rst_ni), .run_i(run_q), .done_o(rc_done), .echo_o(rc_echo)
  );

  // source edge detection
  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_act_q <= 1'b0;
      por_q     <= 1'b0;
      bor_q     <= 1'b0;
      wdt_q     <= 1'b0;
    end else begin
      pin_act_q <= pin_act;
      por_q     <= por_i;
      bor_q     <= bor_lvl;
      wdt_q     <= wdt_to_i;
    end
  end

  assign bor_lvl    = bod_i & bod_en_i;
  assign por_ev     = por_i & ~por_q;
  assign bor_ev     = bor_lvl & ~bor_q;
  assign pin_ev     = pin_act & ~pin_act_q;
  assign wdt_edge   = wdt_to_i & ~wdt_q;
  assign wdt_rst_ev = wdt_edge & ~sleep_i & ~chip_rst_q;
  assign wake_ev    = wdt_edge & sleep_i & ~chip_rst_q & ~(por_ev | bor_ev | pin_ev);
  assign rst_ev     = por_ev | bor_ev | pin_ev | wdt_rst_ev;
  assign restart    = rst_ev | por_i | bor_lvl | pin_act;

  // RC-domain handshake back into oscillator domain
  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_sync <= '0;
      echo_sync <= '0;
    end else begin
      done_sync <= {done_sync[0], rc_done};
      echo_sync <= {echo_sync[0], rc_echo};
    end
  end
  assign done_s = done_sync[1];
  assign echo_s = echo_sync[1];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD: if (!restart) begin
        if (!pwrt_en_i)             state_d = ost_en_i ? ST_OSCUP : ST_RUN;
        else if (!echo_s && !done_s) state_d = ST_PWRUP;
      end
      ST_PWRUP: begin
        if (restart)     state_d = ST_HOLD;
        else if (done_s) state_d = ost_en_i ? ST_OSCUP : ST_RUN;
      end
      ST_OSCUP: begin
        if (restart)                    state_d = ST_HOLD;
        else if (ost_cnt_q == OST_LAST) state_d = ST_RUN;
      end
      ST_RUN: if (restart) state_d = ST_HOLD;
      default: state_d = ST_HOLD;
    endcase
  end

  assign seq_done = (state_q != ST_RUN) && (state_d == ST_RUN);

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HOLD;
      ost_cnt_q  <= '0;
      run_q      <= 1'b0;
      chip_rst_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      run_q     <= (state_d == ST_PWRUP);
      ost_cnt_q <= (state_q == ST_OSCUP && state_d == ST_OSCUP) ? ost_cnt_q + 1'b1 : '0;
      // set/reset latch: sources set, delay chain clears
      if (restart)       chip_rst_q <= 1'b1;
      else if (seq_done) chip_rst_q <= 1'b0;
    end
  end

  rst_cause_track u_cause (
    .clk_i(osc_clk_i), .rst_ni(rst_ni),
    .por_ev_i(por_ev), .bor_ev_i(bor_ev), .pin_ev_i(pin_ev),
    .wdt_ev_i(wdt_rst_ev), .wake_ev_i(wake_ev), .sleep_i(sleep_i),
    .cause_o(cause_w), .to_o(to_o), .pd_o(pd_o), .wake_o(wake_o)
  );

  assign cause_o    = cause_w;
  assign chip_rst_o = chip_rst_q;

  // R13
  latch_state_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    chip_rst_q == (state_q != ST_RUN));

  // R7
  wake_no_rst_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    wake_o |-> !chip_rst_q);

  // R6
  bor_gate_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (cause_w == CAUSE_BOR && $past(cause_w) != CAUSE_BOR) |-> $past(bod_i && bod_en_i));

  // R9
  pwrt_order_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (state_q == ST_OSCUP && $past(state_q) == ST_PWRUP) |-> $past(done_s));

  // R12
  wdt_ignore_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (chip_rst_q && wdt_to_i && !por_i && !bor_lvl && !pin_act) |=> !wake_o);
endmodule

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
  localparam int FILT = 4;
  localparam int PWRT = 16;
  localparam int OST  = 16;
  localparam int RC_HALF = 13;
  localparam int FULL_MIN = PWRT * 2 * RC_HALF + OST * 10;
  localparam int FULL_MAX = FULL_MIN + 330;

  logic osc_clk = 1'b0, rc_clk = 1'b0;
  logic rst_n, ext_rst_n, por, bod, bod_en, wdt, sleep, pwrt_en, ost_en;
  logic chip_rst, to_f, pd_f, wake;
  logic [2:0] cause;

  always #5 osc_clk = ~osc_clk;
  always #(RC_HALF) rc_clk = ~rc_clk;

  rst_seq_top #(.FILT_LEN(FILT), .PWRT_LEN(PWRT), .OST_LEN(OST)) dut_i (
    .osc_clk_i(osc_clk), .rc_clk_i(rc_clk), .rst_ni(rst_n), .ext_rst_ni(ext_rst_n),
    .por_i(por), .bod_i(bod), .bod_en_i(bod_en), .wdt_to_i(wdt), .sleep_i(sleep),
    .pwrt_en_i(pwrt_en), .ost_en_i(ost_en), .chip_rst_o(chip_rst),
    .cause_o(cause), .to_o(to_f), .pd_o(pd_f), .wake_o(wake)
  );

  int checks = 0, fails = 0;
  logic [5:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected item: {wake, cause, to, pd}
  task automatic push(input bit w, input logic [2:0] c, input bit t, input bit p, input string tag);
    exp_q.push_back({w, c, t, p});
    tag_q.push_back(tag);
  endtask

  // monitor: compare on every release and every wake strobe
  initial begin
    logic prev_rst;
    logic [5:0] act, exp;
    string tag;
    prev_rst = 1'b1;
    forever begin
      @(negedge osc_clk);
      if ((prev_rst && !chip_rst) || wake) begin
        act = {wake, cause, to_f, pd_f};
        if (exp_q.size() == 0) chk(1'b0, "unexpected", int'(act), -1);
        else begin
          exp = exp_q.pop_front();
          tag = tag_q.pop_front();
          chk(act == exp, tag, int'(act), int'(exp));
        end
      end
      prev_rst = chip_rst;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge osc_clk);
  endtask

  task automatic pin_pulse(input int n, output time t_end);
    ext_rst_n = 1'b0;
    cyc(n);
    ext_rst_n = 1'b1;
    t_end = $time;
  endtask

  task automatic wait_rel(input time t0, input int lo, input int hi, input string tag);
    time dt;
    @(negedge chip_rst);
    dt = $time - t0;
    chk(dt >= lo && dt <= hi, tag, int'(dt), lo);
    cyc(3);
  endtask

  initial begin
    repeat (100000) @(posedge osc_clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    time t0;
    bit seen;
    rst_n = 0; ext_rst_n = 1; por = 0; bod = 0; bod_en = 0; wdt = 0; sleep = 0;
    pwrt_en = 1; ost_en = 1;
    cyc(3);
    // R1 reset state
    chk(chip_rst == 1'b1, "R1 chip_rst", int'(chip_rst), 1);
    chk(cause == 3'd0, "R1 cause", int'(cause), 0);
    chk(to_f && pd_f, "R1 to/pd", int'({to_f, pd_f}), 3);
    chk(wake == 1'b0, "R1 wake", int'(wake), 0);
    push(0, 3'd0, 1, 1, "R1 first release");
    rst_n = 1; t0 = $time;
    wait_rel(t0, FULL_MIN, FULL_MAX, "R9 first release window");

    // R3 pin reset while running, status unchanged (1,1)
    push(0, 3'd1, 1, 1, "R3 pin run");
    pin_pulse(8, t0);
    wait_rel(t0, FULL_MIN, FULL_MAX, "R9 pin release window");

    // R5 watchdog while running
    push(0, 3'd3, 0, 1, "R5 wdt run");
    wdt = 1; cyc(1); wdt = 0; t0 = $time;
    wait_rel(t0, FULL_MIN, FULL_MAX, "R9 wdt release window");

    // R2 short pin pulse ignored
    seen = 0;
    ext_rst_n = 0; cyc(FILT - 1); ext_rst_n = 1;
    repeat (12) begin cyc(1); if (chip_rst) seen = 1; end
    chk(!seen, "R2 short pulse no reset", int'(seen), 0);
    chk(cause == 3'd3, "R2 short pulse cause kept", int'(cause), 3);

    // R3 pin reset after watchdog keeps to=0,pd=1
    push(0, 3'd1, 0, 1, "R3 pin run keeps status");
    pin_pulse(8, t0);
    wait_rel(t0, FULL_MIN, FULL_MAX, "R9 pin release window 2");

    // R4 pin reset asleep
    sleep = 1;
    push(0, 3'd2, 1, 0, "R4 pin sleep");
    pin_pulse(8, t0);
    wait_rel(t0, FULL_MIN, FULL_MAX, "R9 pin-sleep release window");

    // R7 watchdog wake-up while asleep
    push(1, 3'd5, 0, 0, "R7 wake");
    seen = 0;
    wdt = 1; cyc(1); wdt = 0;
    repeat (8) begin cyc(1); if (chip_rst) seen = 1; end
    chk(!seen, "R7 no chip reset on wake", int'(seen), 0);
    sleep = 0;

    // R6 brown-out disabled has no effect
    seen = 0;
    bod = 1; bod_en = 0;
    repeat (10) begin cyc(1); if (chip_rst) seen = 1; end
    bod = 0; cyc(2);
    chk(!seen, "R6 bod disabled no reset", int'(seen), 0);
    chk(cause == 3'd5, "R6 bod disabled cause kept", int'(cause), 5);

    // R6 brown-out enabled
    bod_en = 1;
    push(0, 3'd4, 1, 1, "R6 bor");
    bod = 1; cyc(5); bod = 0; t0 = $time;
    wait_rel(t0, FULL_MIN, FULL_MAX, "R9 bor release window");

    // R8 power-on wins over watchdog in same cycle
    push(0, 3'd0, 1, 1, "R8 por priority");
    por = 1; wdt = 1; cyc(1); por = 0; wdt = 0; t0 = $time;
    wait_rel(t0, FULL_MIN, FULL_MAX, "R9 por release window");

    // R12 watchdog ignored during hold, asleep or not
    push(0, 3'd4, 1, 1, "R12 wdt ignored in hold");
    bod = 1; cyc(3); bod = 0; t0 = $time;
    cyc(10); wdt = 1; cyc(1); wdt = 0;
    cyc(5); sleep = 1; wdt = 1; cyc(1); wdt = 0; sleep = 0;
    cyc(2);
    chk(cause == 3'd4, "R12 cause unchanged in hold", int'(cause), 4);
    wait_rel(t0, FULL_MIN, FULL_MAX, "R12 release window");

    // R11 restart during power-up delay
    push(0, 3'd1, 1, 1, "R11 restart cause");
    por = 1; cyc(1); por = 0;
    cyc(30);
    pin_pulse(8, t0);
    wait_rel(t0, FULL_MIN, FULL_MAX, "R11 restart window");

    // R10 bypasses
    pwrt_en = 0; ost_en = 0;
    push(0, 3'd1, 1, 1, "R10 both bypassed");
    pin_pulse(8, t0);
    wait_rel(t0, 0, 80, "R10 both bypassed window");
    pwrt_en = 0; ost_en = 1;
    push(0, 3'd1, 1, 1, "R10 pwrt bypassed");
    pin_pulse(8, t0);
    wait_rel(t0, OST * 10, OST * 10 + 100, "R10 pwrt bypassed window");
    pwrt_en = 1; ost_en = 0;
    push(0, 3'd1, 1, 1, "R10 ost bypassed");
    pin_pulse(8, t0);
    wait_rel(t0, PWRT * 2 * RC_HALF, PWRT * 2 * RC_HALF + 250, "R10 ost bypassed window");
    ost_en = 1;

    // R13 held while pin stays low
    seen = 1;
    ext_rst_n = 0; cyc(10);
    repeat (60) begin cyc(1); if (!chip_rst) seen = 0; end
    chk(seen, "R13 held while pin low", int'(seen), 1);
    push(0, 3'd1, 1, 1, "R13 release after long hold");
    ext_rst_n = 1; t0 = $time;
    wait_rel(t0, FULL_MIN, FULL_MAX, "R13 release window");

    cyc(5);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule